// File: doc/BRIEF.md
# Ethernet MAC register and descriptor window

This block is the software-facing register slave of an Ethernet MAC. A 32-bit request/response bus reads and writes the controller's configuration words: operating mode, interrupt source and enable, the three inter-frame gap settings, frame length limits, collision settings, transmit descriptor count, control mode and the management interface words. It also holds the 48-bit station address and gives word access to a descriptor RAM. All configuration goes straight out to the transmit and receive engines. The engines can also read the descriptor RAM through a separate port and can raise interrupt source bits.

Every request gets a response one cycle later. If the address is not word aligned, or is aligned but matches neither a register nor the descriptor window, the response carries an error flag and zero data, and a write has no effect. Writing the transmit descriptor count keeps only its low byte. The same write pulses a load strobe so that the receive engine restarts its descriptor index at that value. The interrupt line is high while any enabled source bit is set.

Top module: `eth_regwin`

## Requirements
- R1: After reset the words read back as follows: mode (offset 0x00) 0x0000A000, tx gap (0x0C) 0x12, rx gap one (0x10) 0x0C, rx gap two (0x14) 0x12, frame length (0x18) 0x003C0600, collision (0x1C) 0x000F003F, tx descriptor count (0x20) 0x80, management mode (0x28) 0x64. Every other register reads 0 and irq is low.
- R2: A request accepted in one cycle gives rsp_valid in the next cycle. An aligned register write is then read back unchanged. Register offsets: 0x00 mode, 0x04 interrupt source, 0x08 interrupt enable, 0x0C to 0x14 gaps, 0x18 frame length, 0x1C collision, 0x20 tx descriptor count, 0x24 control mode, 0x28 to 0x3C management words, 0x40 and 0x44 station address.
- R3: A write to offset 0x20 stores only bits 7:0, and reads return them zero-extended. In the response cycle, rx_idx_load_o is high for exactly one cycle with rx_idx_o equal to the stored byte.
- R4: Station address byte k sits in station_o[8k+7:8k]. Offset 0x40 holds bytes 0 to 3, with byte 0 in bits 7:0. Offset 0x44 holds byte 4 in bits 7:0 and byte 5 in bits 15:8; its bits 31:16 are not stored and read as 0.
- R5: min_len_o is bits 31:16 and max_len_o is bits 15:0 of the frame length word.
- R6: An aligned offset inside the descriptor window [DESC_BASE, DESC_BASE + 4*DESC_WORDS) reaches descriptor word (offset − DESC_BASE)/4. That word can be read and written over the bus, and read on desc_rd_data_o when desc_rd_idx_i selects it.
- R7: A request with offset bits 1:0 not zero responds with rsp_err=1 and rsp_rdata=0, and a rejected write changes nothing.
- R8: An aligned offset in neither the register block (0x00 to 0x44) nor the descriptor window responds with rsp_err=1 and rsp_rdata=0, and a rejected write changes nothing.
- R9: irq is the OR over all bits of (interrupt source AND interrupt enable). A bit raised on irq_set sets the matching source bit in the next cycle.
- R10: A write to the interrupt source replaces its value. irq_set bits raised in the same cycle are ORed on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| irq_set | input | SRC_W | Engine requests to raise interrupt source bits |
| irq | output | 1 | Interrupt line |
| mode_o | output | 32 | Mode word |
| gap_tx_o | output | 32 | Back-to-back transmit gap |
| gap_rx1_o | output | 32 | Non-back-to-back gap, part one |
| gap_rx2_o | output | 32 | Non-back-to-back gap, part two |
| min_len_o | output | 16 | Minimum frame length |
| max_len_o | output | 16 | Maximum frame length |
| coll_o | output | 32 | Collision settings word |
| tx_desc_count_o | output | 8 | Transmit descriptor count |
| ctrl_mode_o | output | 32 | Control mode word |
| mgmt_mode_o | output | 32 | Management mode word |
| mgmt_cmd_o | output | 32 | Management command word |
| mgmt_addr_o | output | 32 | Management address word |
| mgmt_wdata_o | output | 32 | Management transmit data |
| station_o | output | 48 | Station address, byte 0 lowest |
| rx_idx_load_o | output | 1 | Reload strobe for receive descriptor index |
| rx_idx_o | output | 8 | Value to reload |
| desc_rd_idx_i | input | DESC_IW | Engine descriptor word index |
| desc_rd_data_o | output | 32 | Engine descriptor word data |

## Verification
The bench builds the block with ADDR_W=11, DESC_BASE=0x400, DESC_WORDS=64 and SRC_W=7. With this build the descriptor window ends at 0x500, so the bench can reach both the last valid descriptor word (0x4FC) and an aligned address just past the window. A write to 0x500 would alias descriptor word 0 if the window check were missing, so that write checks R8. The bench also drives a software write to the interrupt source and an engine set in the same cycle, which checks the merge rule of R10.

// File: rtl/eth_regwin.sv
module eth_regwin #(
  parameter int ADDR_W     = 11,
  parameter int DESC_WORDS = 256,
  parameter int DESC_BASE  = 'h400,
  parameter int SRC_W      = 7,
  localparam int DESC_IW   = $clog2(DESC_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  input  logic [SRC_W-1:0]   irq_set,
  output logic               irq,
  output logic [31:0]        mode_o,
  output logic [31:0]        gap_tx_o,
  output logic [31:0]        gap_rx1_o,
  output logic [31:0]        gap_rx2_o,
  output logic [15:0]        min_len_o,
  output logic [15:0]        max_len_o,
  output logic [31:0]        coll_o,
  output logic [7:0]         tx_desc_count_o,
  output logic [31:0]        ctrl_mode_o,
  output logic [31:0]        mgmt_mode_o,
  output logic [31:0]        mgmt_cmd_o,
  output logic [31:0]        mgmt_addr_o,
  output logic [31:0]        mgmt_wdata_o,
  output logic [47:0]        station_o,
  output logic               rx_idx_load_o,
  output logic [7:0]         rx_idx_o,
  input  logic [DESC_IW-1:0] desc_rd_idx_i,
  output logic [31:0]        desc_rd_data_o
);

  localparam int  NREGS    = 18;
  localparam int  DESC_END = DESC_BASE + 4 * DESC_WORDS;
  localparam int  WORD_W   = ADDR_W - 2;

  logic [31:0]      mode_q, gtx_q, grx1_q, grx2_q, flen_q, coll_q, ctrl_q;
  logic [31:0]      mmode_q, mcmd_q, maddr_q, mtx_q, mrx_q, mstat_q, sta_lo_q;
  logic [15:0]      sta_hi_q;
  logic [7:0]       txcnt_q;
  logic [SRC_W-1:0] src_q, mask_q;
  logic [31:0]      desc_mem [DESC_WORDS];

  logic [WORD_W-1:0]  word;
  logic [DESC_IW-1:0] didx;
  logic               aligned, in_win, reg_hit, ok, wr, rd_desc;
  logic [31:0]        reg_rd;
  logic [31:0]        addr_ext;

  assign addr_ext = 32'(req_addr);
  assign word     = req_addr[ADDR_W-1:2];
  assign aligned  = req_addr[1:0] == 2'b00;
  assign in_win   = addr_ext >= 32'(DESC_BASE) && addr_ext < 32'(DESC_END);
  assign reg_hit  = aligned && 32'(word) < 32'(NREGS);
  assign ok       = aligned && (reg_hit || in_win);
  assign wr       = req_valid && req_write && ok;
  assign didx     = DESC_IW'((addr_ext - 32'(DESC_BASE)) >> 2);
  assign rd_desc  = req_valid && !req_write && aligned && in_win && !reg_hit;

  always_comb begin
    reg_rd = 32'h0;
    case (32'(word))
      0:  reg_rd = mode_q;
      1:  reg_rd = 32'(src_q);
      2:  reg_rd = 32'(mask_q);
      3:  reg_rd = gtx_q;
      4:  reg_rd = grx1_q;
      5:  reg_rd = grx2_q;
      6:  reg_rd = flen_q;
      7:  reg_rd = coll_q;
      8:  reg_rd = 32'(txcnt_q);
      9:  reg_rd = ctrl_q;
      10: reg_rd = mmode_q;
      11: reg_rd = mcmd_q;
      12: reg_rd = maddr_q;
      13: reg_rd = mtx_q;
      14: reg_rd = mrx_q;
      15: reg_rd = mstat_q;
      16: reg_rd = sta_lo_q;
      17: reg_rd = {16'h0, sta_hi_q};
      default: reg_rd = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 32'h0000A000;
      gtx_q    <= 32'h12;
      grx1_q   <= 32'h0C;
      grx2_q   <= 32'h12;
      flen_q   <= 32'h003C0600;
      coll_q   <= 32'h000F003F;
      txcnt_q  <= 8'h80;
      ctrl_q   <= '0;
      mmode_q  <= 32'h64;
      mcmd_q   <= '0;
      maddr_q  <= '0;
      mtx_q    <= '0;
      mrx_q    <= '0;
      mstat_q  <= '0;
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      mask_q   <= '0;
    end else if (wr && reg_hit) begin
      case (32'(word))
        0:  mode_q   <= req_wdata;
        2:  mask_q   <= req_wdata[SRC_W-1:0];
        3:  gtx_q    <= req_wdata;
        4:  grx1_q   <= req_wdata;
        5:  grx2_q   <= req_wdata;
        6:  flen_q   <= req_wdata;
        7:  coll_q   <= req_wdata;
        8:  txcnt_q  <= req_wdata[7:0];
        9:  ctrl_q   <= req_wdata;
        10: mmode_q  <= req_wdata;
        11: mcmd_q   <= req_wdata;
        12: maddr_q  <= req_wdata;
        13: mtx_q    <= req_wdata;
        14: mrx_q    <= req_wdata;
        15: mstat_q  <= req_wdata;
        16: sta_lo_q <= req_wdata;
        17: sta_hi_q <= req_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= ((wr && reg_hit && 32'(word) == 1) ? req_wdata[SRC_W-1:0] : src_q) | irq_set;
  end

  always_ff @(posedge clk) begin
    if (wr && !reg_hit && in_win) desc_mem[didx] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_rdata     <= '0;
      rx_idx_load_o <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_err       <= req_valid && !ok;
      rx_idx_load_o <= wr && reg_hit && 32'(word) == 8;
      if (req_valid && !req_write && ok) rsp_rdata <= rd_desc ? desc_mem[didx] : reg_rd;
      else                               rsp_rdata <= '0;
    end
  end

  assign irq             = |(src_q & mask_q);
  assign mode_o          = mode_q;
  assign gap_tx_o        = gtx_q;
  assign gap_rx1_o       = grx1_q;
  assign gap_rx2_o       = grx2_q;
  assign min_len_o       = flen_q[31:16];
  assign max_len_o       = flen_q[15:0];
  assign coll_o          = coll_q;
  assign tx_desc_count_o = txcnt_q;
  assign ctrl_mode_o     = ctrl_q;
  assign mgmt_mode_o     = mmode_q;
  assign mgmt_cmd_o      = mcmd_q;
  assign mgmt_addr_o     = maddr_q;
  assign mgmt_wdata_o    = mtx_q;
  assign station_o       = {sta_hi_q, sta_lo_q};
  assign rx_idx_o        = txcnt_q;
  assign desc_rd_data_o  = desc_mem[desc_rd_idx_i];

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_misaligned_err_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'h0));

  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == 32'h0);

  assert_rx_idx_matches_R3: assert property (@(posedge clk) disable iff (rst)
    rx_idx_load_o |-> (tx_desc_count_o == rx_idx_o && rsp_valid && !rsp_err));

  assert_irq_set_sticks_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_set != '0) |=> ((src_q & $past(irq_set)) == $past(irq_set)));

  assert_txcnt_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_idx_load_o) && !rx_idx_load_o && $past(!rst) |-> $stable(tx_desc_count_o));

endmodule

// File: tb/eth_regwin_bench.sv
module eth_regwin_bench;
  localparam int PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 64;
  localparam int SW = 7;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, irq, rx_idx_load_o;
  logic [31:0] rsp_rdata, mode_o, gap_tx_o, gap_rx1_o, gap_rx2_o, coll_o, ctrl_mode_o;
  logic [31:0] mgmt_mode_o, mgmt_cmd_o, mgmt_addr_o, mgmt_wdata_o, desc_rd_data_o;
  logic [15:0] min_len_o, max_len_o;
  logic [7:0] tx_desc_count_o, rx_idx_o;
  logic [47:0] station_o;
  logic [SW-1:0] irq_set = '0;
  logic [5:0] desc_rd_idx_i = '0;

  int checks = 0, failures = 0;
  logic [31:0] r_data;
  logic r_err, r_valid, r_load;
  logic [7:0] r_idx;

  eth_regwin #(.ADDR_W(AW), .DESC_WORDS(DW), .DESC_BASE('h400), .SRC_W(SW)) u_eth_regwin (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_set(irq_set), .irq(irq), .mode_o(mode_o), .gap_tx_o(gap_tx_o), .gap_rx1_o(gap_rx1_o),
    .gap_rx2_o(gap_rx2_o), .min_len_o(min_len_o), .max_len_o(max_len_o), .coll_o(coll_o),
    .tx_desc_count_o(tx_desc_count_o), .ctrl_mode_o(ctrl_mode_o), .mgmt_mode_o(mgmt_mode_o),
    .mgmt_cmd_o(mgmt_cmd_o), .mgmt_addr_o(mgmt_addr_o), .mgmt_wdata_o(mgmt_wdata_o),
    .station_o(station_o), .rx_idx_load_o(rx_idx_load_o), .rx_idx_o(rx_idx_o),
    .desc_rd_idx_i(desc_rd_idx_i), .desc_rd_data_o(desc_rd_data_o));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata; r_load = rx_idx_load_o; r_idx = rx_idx_o;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus(0, a, 0);
    chk(req, {31'b0, r_err}, 0);
    chk(req, r_data, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 mode", 'h00, 32'h0000A000);
    rd_chk("R1 gap_tx", 'h0C, 32'h12);
    rd_chk("R1 gap_rx1", 'h10, 32'h0C);
    rd_chk("R1 gap_rx2", 'h14, 32'h12);
    rd_chk("R1 flen", 'h18, 32'h003C0600);
    rd_chk("R1 coll", 'h1C, 32'h000F003F);
    rd_chk("R1 txcnt", 'h20, 32'h80);
    rd_chk("R1 mgmt_mode", 'h28, 32'h64);
    rd_chk("R1 src", 'h04, 0);
    rd_chk("R1 station", 'h40, 0);
    chk("R1 irq", {63'b0, irq}, 0);
    chk("R5 min reset", min_len_o, 60);
    chk("R5 max reset", max_len_o, 1536);
  endtask

  task automatic t_rw;
    bus(1, 'h00, 32'hDEADBEEF);
    chk("R2 rsp_valid", {63'b0, r_valid}, 1);
    chk("R2 write no err", {63'b0, r_err}, 0);
    rd_chk("R2 mode readback", 'h00, 32'hDEADBEEF);
    chk("R2 mode out", mode_o, 32'hDEADBEEF);
    bus(1, 'h3C, 32'h0BADF00D);
    rd_chk("R2 mgmt status", 'h3C, 32'h0BADF00D);
  endtask

  task automatic t_txcount;
    bus(1, 'h20, 32'h123456A5);
    chk("R3 load pulse", {63'b0, r_load}, 1);
    chk("R3 idx value", r_idx, 8'hA5);
    @(negedge clk);
    chk("R3 load one cycle", {63'b0, rx_idx_load_o}, 0);
    rd_chk("R3 low byte only", 'h20, 32'hA5);
    chk("R3 no load on read", {63'b0, r_load}, 0);
  endtask

  task automatic t_station;
    bus(1, 'h40, 32'h44332211);
    bus(1, 'h44, 32'hFFFF6655);
    chk("R4 station", station_o, 48'h665544332211);
    rd_chk("R4 upper ignored", 'h44, 32'h6655);
  endtask

  task automatic t_flen;
    bus(1, 'h18, 32'h004005EE);
    chk("R5 min", min_len_o, 16'h40);
    chk("R5 max", max_len_o, 16'h5EE);
  endtask

  task automatic t_desc;
    bus(1, 'h400, 32'hA0A0A0A0);
    bus(1, 'h4FC, 32'h5C5C5C5C);
    rd_chk("R6 desc word 0", 'h400, 32'hA0A0A0A0);
    rd_chk("R6 desc word 63", 'h4FC, 32'h5C5C5C5C);
    desc_rd_idx_i = 6'd63; #1;
    chk("R6 engine port 63", desc_rd_data_o, 32'h5C5C5C5C);
    desc_rd_idx_i = 6'd0; #1;
    chk("R6 engine port 0", desc_rd_data_o, 32'hA0A0A0A0);
  endtask

  task automatic t_misalign;
    bus(1, 'h002, 32'h0);
    chk("R7 write err", {63'b0, r_err}, 1);
    rd_chk("R7 mode untouched", 'h00, 32'hDEADBEEF);
    bus(0, 'h401, 0);
    chk("R7 read err", {63'b0, r_err}, 1);
    chk("R7 read zero", r_data, 0);
  endtask

  task automatic t_unmapped;
    bus(0, 'h048, 0);
    chk("R8 gap err", {63'b0, r_err}, 1);
    chk("R8 gap zero", r_data, 0);
    bus(1, 'h500, 32'h77777777);
    chk("R8 past window err", {63'b0, r_err}, 1);
    rd_chk("R8 no alias", 'h400, 32'hA0A0A0A0);
  endtask

  task automatic t_irq;
    bus(1, 'h04, 0);
    bus(1, 'h08, 32'h4);
    @(negedge clk); irq_set = 7'h02;
    @(negedge clk); irq_set = 0;
    chk("R9 masked bit no irq", {63'b0, irq}, 0);
    @(negedge clk); irq_set = 7'h04;
    @(negedge clk); irq_set = 0;
    chk("R9 enabled bit irq", {63'b0, irq}, 1);
    rd_chk("R9 src bits", 'h04, 32'h06);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 'h04; req_wdata = 32'h1; irq_set = 7'h40;
    @(negedge clk);
    req_valid = 0; req_write = 0; irq_set = 0;
    rd_chk("R10 write merges set", 'h04, 32'h41);
    chk("R10 irq low after replace", {63'b0, irq}, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_rw;
    t_txcount;
    t_station;
    t_flen;
    t_desc;
    t_misalign;
    t_unmapped;
    t_irq;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule